// File: doc/BRIEF.md
# Counting Semaphore Synchronization Cell

This block is one memory-mapped storage cell that holds a 16-bit count used by hardware threads to synchronize. A thread takes a unit with a load, which returns the count held before the access and then lowers it by one. It gives a unit back with a store, which raises the count by one. Each request carries a thread number, a read/write flag, a view code and a data word.

Two semaphore views exist. The synchronized view holds a reader that finds the count at zero. The cell raises a one-cycle stall pulse and records the thread in a bitmap of waiting threads. The try view never holds a reader: a load that finds zero returns 0. A control view reads and writes the cell's tag, which has empty and full flags and a fixed cell-type flag that marks this cell as a semaphore.

When a store arrives while threads are waiting, the lowest-numbered waiting thread is released. It takes the unit the store supplied, so the count stays at zero. Its pending load is answered with the value 1, tagged with that thread's number.

Top module: `sem_cell`

## Requirements
- R1: After synchronous reset the count is 0, the waiting bitmap is all zero, both tag flags are 0, and rsp_valid and stall are low.
- R2: A load in view 1 (synchronized) or view 2 (try) that finds a nonzero count returns that count on rsp_data with rsp_valid and rsp_tid equal to the requester in the next cycle, and the count drops by one.
- R3: A store in view 1 or 2 with no waiting thread adds exactly 1 to the count, whatever the store data, and gives no response. A store at 0xFFFF leaves the count at 0xFFFF.
- R4: A view 1 load that finds a zero count gives no response. In the next cycle stall pulses high for one cycle and blocked_map bit req_tid is set.
- R5: A view 2 load that finds a zero count responds with data 0 in the next cycle, leaves the count at 0, and does not stall.
- R6: A store in view 1 or 2 while blocked_map is nonzero clears the lowest set bit and responds in the next cycle with rsp_tid equal to that bit's index and data 1. The count remains 0.
- R7: A view 0 (control) read responds with the tag word: bit 0 is the empty flag, bit 1 is the full flag, bit 2 is the cell-type flag (always 0), and all other bits are 0. A view 0 write loads empty from data bit 0 and full from data bit 1, gives no response, and leaves the count unchanged.
- R8: Semaphore accesses in views 1 and 2 never change the empty or full flags.
- R9: A request with view code 3 gives no response and changes neither the count, the tag nor the waiting bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | TID_W (3) | Issuing thread number |
| req_write | input | 1 | 1 = store, 0 = load |
| req_view | input | 2 | 0 control, 1 synchronized, 2 try, 3 reserved |
| req_data | input | CNT_W (16) | Store data (only bits 1:0 used, control view) |
| rsp_valid | output | 1 | Load response present |
| rsp_tid | output | TID_W (3) | Thread the response belongs to |
| rsp_data | output | CNT_W (16) | Load result |
| stall | output | 1 | One-cycle pulse: the previous request's thread is now waiting |
| blocked_map | output | NTHR (8) | One bit per waiting thread |

## Verification
Every result is registered once. A request presented before a rising edge shows its response, stall pulse and bitmap change just after that same edge. A release caused by a store appears in the same cycle a plain load response would. The bench drives each request on the falling edge and compares all outputs to its model one time unit after the following rising edge. It does this every cycle, including idle cycles, so a late, early or repeated response is caught. The count is observed only through later try-view loads.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        VW_CTRL = 2'd0,
        VW_SYNC = 2'd1,
        VW_TRY  = 2'd2,
        VW_RSVD = 2'd3
    } view_e;

    typedef struct packed {
        logic full;
        logic empty;
    } tag_t;

    localparam int TAG_TYPE_BIT = 2;

    function automatic logic [15:0] tag_word(input tag_t t);
        logic [15:0] w;
        w = '0;
        w[0] = t.empty;
        w[1] = t.full;
        w[TAG_TYPE_BIT] = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/sem_count.sv
module sem_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && !dec && count != MAXV)
            count <= count + 1'b1;
        else if (dec && !inc && count != '0)
            count <= count - 1'b1;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (inc && count == MAXV) |=> count == MAXV); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec |-> count != '0); // R2
endmodule

// File: rtl/sem_waitq.sv
module sem_waitq #(
    parameter int N  = 8,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [TW-1:0] set_tid,
    input  logic          wake_en,
    output logic [N-1:0]  map,
    output logic          any,
    output logic [TW-1:0] pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--)
            if (map[i]) pick = TW'(i);
    end

    assign any = |map;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                map[g] <= 1'b0;
            else if (set_en && set_tid == TW'(g))
                map[g] <= 1'b1;
            else if (wake_en && pick == TW'(g))
                map[g] <= 1'b0;
        end
    end

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wake_en && any) |=> !map[$past(pick)]); // R6
    AST_WAKE_ONE: assert property (@(posedge clk) disable iff (rst)
        (wake_en && !set_en) |=> $countones(map) == $countones($past(map)) - 1); // R6
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter int NTHR  = 8,
    parameter int CNT_W = 16,
    parameter int TID_W = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TID_W-1:0] req_tid,
    input  logic             req_write,
    input  logic [1:0]       req_view,
    input  logic [CNT_W-1:0] req_data,
    output logic             rsp_valid,
    output logic [TID_W-1:0] rsp_tid,
    output logic [CNT_W-1:0] rsp_data,
    output logic             stall,
    output logic [NTHR-1:0]  blocked_map
);
    view_e            vw;
    logic             is_sem, ld, st, cz;
    logic             do_dec, do_blk, do_wake, do_inc;
    logic             ctl_rd, ctl_wr;
    logic             any_wait;
    logic [TID_W-1:0] pick_tid;
    logic [CNT_W-1:0] count;
    tag_t             tag_q;
    logic             rv_n;
    logic [TID_W-1:0] tid_n;
    logic [CNT_W-1:0] data_n;
    logic             unused_data;

    assign vw          = view_e'(req_view);
    assign unused_data = ^req_data[CNT_W-1:2];
    assign is_sem      = (vw == VW_SYNC) || (vw == VW_TRY);
    assign ld          = req_valid && !req_write && is_sem;
    assign st          = req_valid &&  req_write && is_sem;
    assign ctl_rd      = req_valid && !req_write && (vw == VW_CTRL);
    assign ctl_wr      = req_valid &&  req_write && (vw == VW_CTRL);
    assign cz          = (count == '0);
    assign do_dec      = ld && !cz;
    assign do_blk      = ld && cz && (vw == VW_SYNC);
    assign do_wake     = st && any_wait;
    assign do_inc      = st && !any_wait;

    sem_count #(.W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .inc(do_inc), .dec(do_dec), .count(count)
    );

    sem_waitq #(.N(NTHR), .TW(TID_W)) u_waitq (
        .clk(clk), .rst(rst), .set_en(do_blk), .set_tid(req_tid),
        .wake_en(do_wake), .map(blocked_map), .any(any_wait), .pick(pick_tid)
    );

    always_comb begin
        rv_n   = ctl_rd || (ld && !do_blk) || do_wake;
        tid_n  = do_wake ? pick_tid : req_tid;
        data_n = '0;
        if (ctl_rd)
            data_n = CNT_W'(tag_word(tag_q));
        else if (do_wake)
            data_n = CNT_W'(1);
        else if (do_dec)
            data_n = count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_data  <= '0;
            stall     <= 1'b0;
        end else begin
            if (ctl_wr) begin
                tag_q.empty <= req_data[0];
                tag_q.full  <= req_data[1];
            end
            rsp_valid <= rv_n;
            rsp_tid   <= tid_n;
            rsp_data  <= data_n;
            stall     <= do_blk;
        end
    end

    AST_WAIT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (|blocked_map) |-> count == '0); // R6
    AST_LOAD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (ld && !cz) |=> rsp_valid && rsp_data == $past(count)); // R2
    AST_BLOCK_MARK: assert property (@(posedge clk) disable iff (rst)
        do_blk |=> stall && !rsp_valid && blocked_map[$past(req_tid)]); // R4
    AST_TAG_KEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_sem) |=> $stable(tag_q)); // R8
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && vw == VW_RSVD) |=> !rsp_valid && !stall && $stable(count)); // R9
endmodule

// File: tb/sim_sem_cell.sv
module sim_sem_cell;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_tid = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_view = '0;
    logic [15:0] req_data = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_tid;
    logic [15:0] rsp_data;
    logic        stall;
    logic [7:0]  blocked_map;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int       m_cnt = 0;
    bit [7:0] m_wait = '0;
    bit       m_empty = 0;
    bit       m_full = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_cell u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
        .req_write(req_write), .req_view(req_view), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
        .stall(stall), .blocked_map(blocked_map)
    );

    task automatic step(input bit v, input int tid, input bit wr, input int view,
                        input int data, input string req);
        bit       ev = 0;
        int       etid = tid;
        int       edata = 0;
        bit       est = 0;
        bit       ok;
        if (v) begin
            if (view == 0) begin
                if (wr) begin m_empty = data[0]; m_full = data[1]; end
                else begin ev = 1; edata = {m_full, m_empty}; end
            end else if (view == 1 || view == 2) begin
                if (wr) begin
                    if (m_wait != 0) begin
                        for (int i = NT - 1; i >= 0; i--) if (m_wait[i]) etid = i;
                        m_wait[etid] = 0; ev = 1; edata = 1;
                    end else if (m_cnt < 65535) m_cnt++;
                end else if (m_cnt > 0) begin
                    ev = 1; edata = m_cnt; m_cnt--;
                end else if (view == 1) begin
                    m_wait[tid] = 1; est = 1;
                end else begin
                    ev = 1; edata = 0;
                end
            end
        end
        @(negedge clk);
        req_valid = v; req_tid = 3'(tid); req_write = wr;
        req_view = 2'(view); req_data = 16'(data);
        @(posedge clk);
        #1;
        ok = (rsp_valid == ev) && (stall == est) && (blocked_map == m_wait) &&
             (!ev || (rsp_tid == 3'(etid) && rsp_data == 16'(edata)));
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act v=%0b tid=%0d d=%0d st=%0b map=%b exp v=%0b tid=%0d d=%0d st=%0b map=%b",
                     req, rsp_valid, rsp_tid, rsp_data, stall, blocked_map,
                     ev, etid, edata, est, m_wait);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: act timeout exp finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        checks++;
        if (rsp_valid !== 1'b0 || stall !== 1'b0 || blocked_map !== 8'h00) begin
            fails++;
            $display("FAIL R1: act v=%0b st=%0b map=%b exp 0 0 0", rsp_valid, stall, blocked_map);
        end
        step(1, 0, 0, 0, 0, "R1");        // tag reads 0
        step(1, 1, 0, 2, 0, "R5");        // try load at zero
        step(0, 0, 0, 0, 0, "R1");
        // releases with varied store data (ignored)
        step(1, 3, 1, 1, 16'hFFFF, "R3");
        step(1, 4, 1, 2, 16'h1234, "R3");
        step(1, 0, 1, 1, 0, "R3");
        step(1, 2, 0, 1, 0, "R2");        // returns 3
        step(1, 7, 0, 2, 0, "R2");        // returns 2
        step(1, 1, 0, 1, 0, "R2");        // returns 1
        step(1, 1, 0, 2, 0, "R5");        // returns 0, no stall
        // stalled readers
        step(1, 5, 0, 1, 0, "R4");
        step(1, 2, 0, 1, 0, "R4");
        step(1, 6, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 0, "R4");
        step(1, 0, 1, 2, 16'h00AA, "R6");  // wakes thread 2
        step(1, 3, 1, 1, 0, "R6");        // wakes thread 5
        step(1, 0, 0, 2, 0, "R6");        // count still 0
        step(1, 4, 1, 1, 0, "R6");        // wakes thread 6
        step(1, 4, 1, 1, 0, "R3");        // no waiter: count 1
        // tag control
        step(1, 0, 1, 0, 16'hFFFF, "R7");
        step(1, 0, 0, 0, 0, "R7");        // reads 3
        step(1, 0, 1, 0, 16'h0002, "R7");
        step(1, 1, 0, 0, 0, "R7");        // reads 2
        step(1, 2, 1, 1, 16'h0001, "R8");
        step(1, 2, 0, 2, 0, "R8");
        step(1, 2, 0, 1, 0, "R8");
        step(1, 3, 0, 1, 0, "R8");        // blocks thread 3
        step(1, 3, 0, 0, 0, "R8");        // tag still 2
        step(1, 0, 1, 0, 16'h0001, "R7");
        step(1, 0, 1, 2, 0, "R6");        // wakes 3
        // reserved view
        step(1, 4, 1, 3, 16'h0003, "R9");
        step(1, 4, 0, 3, 0, "R9");
        step(1, 4, 0, 3, 0, "R9");
        step(1, 5, 0, 0, 0, "R9");        // tag unchanged (1)
        step(1, 5, 0, 2, 0, "R9");        // count still 0
        step(1, 5, 0, 1, 0, "R9");        // block 5
        step(1, 6, 1, 3, 0, "R9");        // must not wake
        step(1, 6, 1, 1, 0, "R6");        // wakes 5
        // saturation
        for (int k = 0; k < 65537; k++) step(1, k % 8, 1, 1, k, "R3");
        step(1, 0, 0, 2, 0, "R3");        // returns 0xFFFF
        step(1, 0, 0, 2, 0, "R2");        // returns 0xFFFE
        step(0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule